// File: doc/BRIEF.md
# Single-Cell Lithium Charge Sequencing Controller

This block is the digital sequencer of a single-cell lithium charger. It watches a set of comparator flags from the analog side: battery below the precondition minimum, battery at the constant-voltage set point, charge current below the termination level, battery below the restart level, die over-temperature, thermistor hot and thermistor cold, input undervoltage and auxiliary supply good. From these flags, an enable pin and a one-second tick it chooses the mode the analog current/voltage loop must run in, and it reports a state code for the status indicators.

Two timers run on the one-second tick. The precondition timer has a fixed limit set by a parameter. The safety timer has a limit taken from an input, so the charge window can be set anywhere from one to ten hours. A timer that expires latches a fault, and only a reset or a low-then-high cycle of the enable clears it. A temperature condition pauses both timers and parks the sequencer in a temperature-fault state. When the condition clears, the sequencer returns to the state it left, except that a pause taken during constant-voltage charging ends in done. All flags and the enable pass through two-flop synchronizers before the state logic uses them. The tick is a single-cycle pulse from the same clock domain.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While reset is high the status is 0 (initiate) and the mode is 0 (off). Status codes: 0 initiate, 1 precondition, 2 constant current, 3 constant voltage, 4 done, 5 timer fault, 6 temperature fault, 7 disabled. Mode codes: 0 off, 1 precondition, 2 constant current, 3 constant voltage.
- R2: Initiate is left only when the input undervoltage flag is low and the auxiliary-good flag is high. It goes to precondition if the battery is below the minimum, and to constant current otherwise.
- R3: Precondition moves to constant current once the below-minimum flag clears. After PRE_SECS ticks counted in precondition it moves to the timer fault. If the flag clears on the same cycle as the expiry, constant current wins.
- R4: The safety timer counts ticks in constant-current and constant-voltage states and is cleared in initiate and disabled. When the count reaches `safety_secs`, the state moves to the timer fault.
- R5: Constant current moves to constant voltage on the set-point flag. Constant voltage moves to done on the termination flag. A termination seen on the same cycle as safety expiry goes to done.
- R6: The timer fault holds while the enable stays high, whatever the other flags do. Enable low, then high, leads through disabled to initiate.
- R7: A temperature flag (die, thermistor hot, thermistor cold) takes the state from initiate, precondition, constant current, constant voltage or done to the temperature fault. It takes priority over timer expiry on the same cycle. The timers hold their counts during the temperature fault, and the previous state is resumed when the flag clears.
- R8: A temperature fault entered from constant voltage ends in done when it clears.
- R9: Done returns to initiate when the below-restart flag is seen.
- R10: The mode output is 0 no later than two clock edges after the enable pin is sampled low, and the state becomes disabled on the next edge.
- R11: A change on any flag or enable pin changes the state no earlier than the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_en | input | 1 | Charger enable, active high (asynchronous) |
| tick_1s | input | 1 | One-cycle pulse per second, clock-domain synchronous |
| batt_below_min | input | 1 | Battery below precondition minimum |
| batt_at_cv | input | 1 | Battery at constant-voltage set point |
| ichg_below_term | input | 1 | Charge current below termination level |
| batt_below_restart | input | 1 | Battery below restart level |
| die_over_temp | input | 1 | Die over-temperature |
| therm_hot | input | 1 | Thermistor hot |
| therm_cold | input | 1 | Thermistor cold |
| vin_uv | input | 1 | Input supply undervoltage |
| aux_good | input | 1 | Auxiliary supply above its trip level |
| safety_secs | input | TW | Safety timer limit in ticks |
| chg_mode | output | 2 | Mode for the analog loop |
| chg_status | output | 3 | State code for the indicators |

## Verification
Two events can fall on the same cycle: a timer reaching its limit, and either a progress flag (termination in constant voltage) or a temperature flag. The bench sets a small safety limit and pulses the tick so that the final count lands on the same edge at which the synchronized flag first becomes visible. It then judges the winner from the resulting state code: done for termination, then the temperature fault followed by the timer fault once the temperature flag clears. A cycle-accurate behavioural model also compares mode and status on every clock.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_INIT      = 3'd0,
        ST_PRE       = 3'd1,
        ST_CC        = 3'd2,
        ST_CV        = 3'd3,
        ST_DONE      = 3'd4,
        ST_TMR_FAULT = 3'd5,
        ST_TMP_FAULT = 3'd6,
        ST_OFF       = 3'd7
    } chg_state_e;

    typedef enum logic [1:0] {
        MD_OFF = 2'd0,
        MD_PRE = 2'd1,
        MD_CC  = 2'd2,
        MD_CV  = 2'd3
    } chg_mode_e;

    // Synchronized view of every pin the state logic reads.
    typedef struct packed {
        logic en;
        logic aux_good;
        logic vin_uv;
        logic th_cold;
        logic th_hot;
        logic die_hot;
        logic restart;
        logic term;
        logic at_cv;
        logic batt_low;
    } chg_flags_t;

    localparam int FLAG_W = $bits(chg_flags_t);

    function automatic chg_mode_e mode_of(chg_state_e s);
        case (s)
            ST_PRE:  return MD_PRE;
            ST_CC:   return MD_CC;
            ST_CV:   return MD_CV;
            default: return MD_OFF;
        endcase
    endfunction

    function automatic logic temp_bad(chg_flags_t f);
        return f.die_hot | f.th_hot | f.th_cold;
    endfunction

    function automatic logic pausable(chg_state_e s);
        return (s == ST_INIT) || (s == ST_PRE) || (s == ST_CC) ||
               (s == ST_CV) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/chg_sec_timer.sv
module chg_sec_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] lim,
    output logic [TW-1:0] cnt,
    output logic          expired
);
    assign expired = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && tick && !expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
    import chg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chg_flags_t f,
    input  logic       pre_exp,
    input  logic       saf_exp,
    output chg_state_e st,
    output chg_mode_e  mode,
    output logic       pre_run,
    output logic       saf_run,
    output logic       tmr_clr
);
    chg_state_e nxt, ret, nxt_ret;

    always_comb begin
        nxt     = st;
        nxt_ret = ret;
        if (!f.en) begin
            nxt = ST_OFF;
        end else if (temp_bad(f) && pausable(st)) begin
            nxt     = ST_TMP_FAULT;
            nxt_ret = st;
        end else begin
            case (st)
                ST_OFF:  nxt = ST_INIT;
                ST_INIT: if (!f.vin_uv && f.aux_good)
                             nxt = f.batt_low ? ST_PRE : ST_CC;
                ST_PRE:  if (!f.batt_low)    nxt = ST_CC;
                         else if (pre_exp)   nxt = ST_TMR_FAULT;
                ST_CC:   if (saf_exp)        nxt = ST_TMR_FAULT;
                         else if (f.at_cv)   nxt = ST_CV;
                ST_CV:   if (f.term)         nxt = ST_DONE;
                         else if (saf_exp)   nxt = ST_TMR_FAULT;
                ST_DONE: if (f.restart)      nxt = ST_INIT;
                ST_TMP_FAULT:
                         if (!temp_bad(f))   nxt = (ret == ST_CV) ? ST_DONE : ret;
                default: nxt = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_INIT;
            ret <= ST_INIT;
        end else begin
            st  <= nxt;
            ret <= nxt_ret;
        end
    end

    assign mode    = f.en ? mode_of(st) : MD_OFF;
    assign pre_run = (st == ST_PRE);
    assign saf_run = (st == ST_CC) || (st == ST_CV);
    assign tmr_clr = (st == ST_INIT) || (st == ST_OFF);
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int TW          = 16,
    parameter int PRE_SECS    = 1800,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chg_en,
    input  logic          tick_1s,
    input  logic          batt_below_min,
    input  logic          batt_at_cv,
    input  logic          ichg_below_term,
    input  logic          batt_below_restart,
    input  logic          die_over_temp,
    input  logic          therm_hot,
    input  logic          therm_cold,
    input  logic          vin_uv,
    input  logic          aux_good,
    input  logic [TW-1:0] safety_secs,
    output logic [1:0]    chg_mode,
    output logic [2:0]    chg_status
);
    localparam logic [TW-1:0] PRE_LIM = PRE_SECS[TW-1:0];

    chg_flags_t raw, syn;
    chg_state_e st;
    chg_mode_e  mode;
    logic       pre_run, saf_run, tmr_clr, pre_exp, saf_exp;
    logic [TW-1:0] pre_cnt, saf_cnt;

    assign raw = chg_flags_t'({chg_en, aux_good, vin_uv, therm_cold, therm_hot,
                               die_over_temp, batt_below_restart, ichg_below_term,
                               batt_at_cv, batt_below_min});

    chg_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    chg_fsm u_fsm (
        .clk(clk), .rst(rst), .f(syn), .pre_exp(pre_exp), .saf_exp(saf_exp),
        .st(st), .mode(mode), .pre_run(pre_run), .saf_run(saf_run), .tmr_clr(tmr_clr)
    );

    chg_sec_timer #(.TW(TW)) u_pre_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(pre_run), .tick(tick_1s),
        .lim(PRE_LIM), .cnt(pre_cnt), .expired(pre_exp)
    );

    chg_sec_timer #(.TW(TW)) u_saf_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(saf_run), .tick(tick_1s),
        .lim(safety_secs), .cnt(saf_cnt), .expired(saf_exp)
    );

    assign chg_mode   = mode;
    assign chg_status = st;
endmodule

module chg_seq_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          chg_en,
    input logic [1:0]    chg_mode,
    input logic [2:0]    chg_status,
    input logic [TW-1:0] pre_cnt,
    input logic [TW-1:0] saf_cnt
);
    // R2
    init_exit_chk: assert property (@(posedge clk) disable iff (rst)
        chg_status == 3'd0 |=> chg_status inside {3'd0, 3'd1, 3'd2, 3'd6, 3'd7});

    // R6
    tmr_fault_latch_chk: assert property (@(posedge clk) disable iff (rst)
        chg_status == 3'd5 |=> chg_status inside {3'd5, 3'd7});

    // R7
    tmp_pause_chk: assert property (@(posedge clk) disable iff (rst)
        chg_status == 3'd6 |=> ($stable(saf_cnt) && $stable(pre_cnt)));

    // R8
    cv_no_resume_chk: assert property (@(posedge clk) disable iff (rst)
        chg_status == 3'd6 |=> chg_status != 3'd3);

    // R9
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        chg_status == 3'd4 |=> chg_status inside {3'd0, 3'd4, 3'd6, 3'd7});

    // R10
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !chg_en |-> ##2 (chg_mode == 2'd0));
endmodule

bind chg_seq_ctrl chg_seq_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .chg_en(chg_en), .chg_mode(chg_mode),
    .chg_status(chg_status), .pre_cnt(pre_cnt), .saf_cnt(saf_cnt)
);

// File: tb/chg_seq_ctrl_bench.sv
module chg_seq_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int TW    = 16;
    localparam int PRE_T = 60;

    // own bit order for the model pipeline
    localparam int B_LOW = 0, B_CV = 1, B_TERM = 2, B_RST = 3, B_DIE = 4,
                   B_HOT = 5, B_COLD = 6, B_UV = 7, B_AUX = 8, B_EN = 9;

    logic clk = 0, rst = 1;
    logic en = 0, tick = 0, batt_low = 0, at_cv = 0, term = 0, restart = 0;
    logic die_hot = 0, t_hot = 0, t_cold = 0, uv = 0, aux = 0;
    logic [TW-1:0] safety = 16'd20;
    logic [1:0] mode;
    logic [2:0] status;

    int total = 0, bad = 0;
    bit cmp_on = 0, finished = 0;
    string phase = "R1";

    always #(CLK_P/2) clk = ~clk;

    chg_seq_ctrl #(.TW(TW), .PRE_SECS(PRE_T)) u_chg_seq_ctrl (
        .clk(clk), .rst(rst), .chg_en(en), .tick_1s(tick),
        .batt_below_min(batt_low), .batt_at_cv(at_cv), .ichg_below_term(term),
        .batt_below_restart(restart), .die_over_temp(die_hot), .therm_hot(t_hot),
        .therm_cold(t_cold), .vin_uv(uv), .aux_good(aux), .safety_secs(safety),
        .chg_mode(mode), .chg_status(status)
    );

    // ---------------- behavioural reference model ----------------
    int m_st = 0, m_ret = 0, m_pre = 0, m_saf = 0;
    int n_st, n_ret, n_pre, n_saf;
    logic [9:0] m_s1 = '0, m_s2 = '0, pins;
    bit hot, pre_exp, saf_exp;

    always @(posedge clk) begin
        pins = {en, aux, uv, t_cold, t_hot, die_hot, restart, term, at_cv, batt_low};
        if (rst) begin
            m_st = 0; m_ret = 0; m_pre = 0; m_saf = 0; m_s1 = '0; m_s2 = '0;
        end else begin
            hot     = m_s2[B_DIE] | m_s2[B_HOT] | m_s2[B_COLD];
            pre_exp = (m_pre >= PRE_T);
            saf_exp = (m_saf >= int'(safety));
            if (m_st == 0 || m_st == 7) begin
                n_pre = 0; n_saf = 0;
            end else begin
                n_pre = m_pre + ((m_st == 1 && tick && !pre_exp) ? 1 : 0);
                n_saf = m_saf + (((m_st == 2 || m_st == 3) && tick && !saf_exp) ? 1 : 0);
            end
            n_st = m_st; n_ret = m_ret;
            if (!m_s2[B_EN]) n_st = 7;
            else if (hot && m_st <= 4) begin n_st = 6; n_ret = m_st; end
            else begin
                case (m_st)
                    7: n_st = 0;
                    0: if (!m_s2[B_UV] && m_s2[B_AUX]) n_st = m_s2[B_LOW] ? 1 : 2;
                    1: if (!m_s2[B_LOW]) n_st = 2; else if (pre_exp) n_st = 5;
                    2: if (saf_exp) n_st = 5; else if (m_s2[B_CV]) n_st = 3;
                    3: if (m_s2[B_TERM]) n_st = 4; else if (saf_exp) n_st = 5;
                    4: if (m_s2[B_RST]) n_st = 0;
                    6: if (!hot) n_st = (m_ret == 3) ? 4 : m_ret;
                    default: ;
                endcase
            end
            m_st = n_st; m_ret = n_ret; m_pre = n_pre; m_saf = n_saf;
            m_s2 = m_s1; m_s1 = pins;
        end
    end

    function automatic int model_mode();
        return (m_s2[B_EN] && m_st >= 1 && m_st <= 3) ? m_st : 0;
    endfunction

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            total++;
            if (int'(status) != m_st || int'(mode) != model_mode()) begin
                bad++;
                $display("FAIL %s per-cycle: actual status=%0d mode=%0d expected status=%0d mode=%0d",
                         phase, status, mode, m_st, model_mode());
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic en_cycle();
        en = 0; cyc(3); en = 1; cyc(4);
    endtask

    initial begin
        cyc(3);
        cmp_on = 1;
        chk("R1 reset status", status, 0);
        chk("R1 reset mode", mode, 0);
        rst = 0; cyc(4);
        phase = "R10";
        chk("R10 disabled after reset with enable low", status, 7);

        phase = "R2";
        en = 1; cyc(6);
        chk("R2 held in initiate without aux supply", status, 0);
        aux = 1; batt_low = 1; cyc(2);
        chk("R11 no change before third edge", status, 0);
        cyc(1);
        chk("R2 initiate to precondition", status, 1);
        chk("R3 precondition mode", mode, 1);

        phase = "R3";
        tick = 1; cyc(10); batt_low = 0; cyc(3);
        chk("R3 precondition to constant current", status, 2);
        phase = "R5";
        cyc(5); at_cv = 1; cyc(3);
        chk("R5 constant current to constant voltage", status, 3);
        term = 1; cyc(3);
        chk("R5 constant voltage to done", status, 4);
        tick = 0; at_cv = 0; term = 0; cyc(3);

        phase = "R9";
        restart = 1; cyc(3);
        chk("R9 done to initiate", status, 0);
        restart = 0; cyc(1);
        chk("R2 initiate straight to constant current", status, 2);

        phase = "R4";
        tick = 1; cyc(30);
        chk("R4 safety timeout in constant current", status, 5);

        phase = "R6";
        at_cv = 1; t_hot = 1; cyc(5);
        chk("R6 timer fault latched", status, 5);
        t_hot = 0; at_cv = 0; safety = 16'd30; en = 0; cyc(3);
        chk("R6 enable low gives disabled", status, 7);
        chk("R10 mode off when disabled", mode, 0);
        en = 1; cyc(3);
        chk("R6 enable high gives initiate", status, 0);
        cyc(1);
        chk("R6 restart into constant current", status, 2);

        phase = "R7";
        cyc(6); die_hot = 1; cyc(3);
        chk("R7 temperature fault from constant current", status, 6);
        chk("R7 mode off in temperature fault", mode, 0);
        cyc(40);
        chk("R7 temperature fault holds", status, 6);
        die_hot = 0; cyc(3);
        chk("R7 return to constant current", status, 2);
        cyc(6);
        chk("R7 safety count paused, not expired", status, 2);
        cyc(20);
        chk("R4 safety timeout after resume", status, 5);

        phase = "R8";
        tick = 0; en_cycle();
        chk("R8 setup constant current", status, 2);
        at_cv = 1; cyc(3);
        chk("R8 setup constant voltage", status, 3);
        t_cold = 1; cyc(3);
        chk("R8 temperature fault from constant voltage", status, 6);
        t_cold = 0; at_cv = 0; cyc(3);
        chk("R8 constant-voltage pause ends in done", status, 4);

        phase = "R7";
        batt_low = 1; restart = 1; cyc(3);
        chk("R9 done to initiate again", status, 0);
        restart = 0; cyc(1);
        chk("R2 initiate to precondition again", status, 1);
        t_hot = 1; cyc(3);
        chk("R7 temperature fault from precondition", status, 6);
        t_hot = 0; cyc(3);
        chk("R7 return to precondition", status, 1);

        phase = "R3";
        tick = 1; cyc(PRE_T + 10);
        chk("R3 precondition timeout", status, 5);

        phase = "R5";
        tick = 0; safety = 16'd5; batt_low = 0; en_cycle();
        chk("R5 setup constant current", status, 2);
        at_cv = 1; cyc(3);
        chk("R5 setup constant voltage", status, 3);
        tick = 1; cyc(3); term = 1; cyc(2); tick = 0; cyc(3);
        chk("R5 termination wins over coincident expiry", status, 4);

        phase = "R7";
        term = 0; at_cv = 0; restart = 1; cyc(3);
        chk("R9 initiate before coincidence test", status, 0);
        restart = 0; cyc(1);
        chk("R7 setup constant current", status, 2);
        tick = 1; cyc(3); die_hot = 1; cyc(2); tick = 0; cyc(3);
        chk("R7 temperature wins over coincident expiry", status, 6);
        cyc(5);
        chk("R7 temperature fault holds over expired timer", status, 6);
        die_hot = 0; cyc(5);
        chk("R4 expiry after temperature clears", status, 5);

        phase = "R10";
        en_cycle();
        chk("R10 setup constant current", status, 2);
        en = 0; cyc(2);
        chk("R10 mode off two edges after enable low", mode, 0);
        chk("R11 state unchanged before third edge", status, 2);
        cyc(1);
        chk("R10 disabled after enable low", status, 7);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule